// File: doc/BRIEF.md
# Key-Protected Sequence Table Register File

This block stores the instruction table that a serial-flash sequence engine runs from: a bank of 64 words of 32 bits. Software reaches the table through a simple word-addressed register port. The same port carries a key register and a lock-control register. The engine fetches instructions through a separate read port that never stalls.

The table can be write-protected. Protection changes state only through a two-step handshake. The first step is a write of the magic value 0x5AF05AF0 to the key register. The write that comes straight after it must then go to the lock-control register and carry 1 to lock the table or 2 to unlock it. Any other register write in between cancels the key. Idle cycles with no write do not cancel it.

After reset the table holds all zeros, which the engine decodes as a stop instruction, and the table is unlocked. The expected use is to clear and program the table while it is open, then lock it before the engine runs.

The address map uses word addresses:
- 0 is the key register, which is write-only and reads 0.
- 1 is lock control.
- 2 to 65 are table entries 0 to 63.
- Every other address reads 0 and ignores writes.

Top module: `seqtab_regfile`

## Requirements
- R1: After reset every table entry reads 0, the lock-control register reads 2 (bit 0 = locked, bit 1 = unlocked), and `table_locked` is 0.
- R2: While unlocked, a write to word address 2+i stores the data in entry i, and a read of that address returns it.
- R3: The sequence read port returns, in the same cycle, the entry selected by `seq_rd_idx`, and it agrees with the register port for the same entry.
- R4: A write of 0x5AF05AF0 to address 0 and then a write of 1 to address 1 locks the table. Cycles with no write between the two steps are allowed. While locked, address 1 reads 1 and `table_locked` is 1.
- R5: While locked, writes to table entries have no effect, and reads from both ports still return the stored contents.
- R6: A key write followed by a write of 2 to address 1 unlocks the table, and table writes are accepted again.
- R7: A lock-control write that is not directly preceded by a correct key write has no effect on the lock state.
- R8: Any register write between the key write and the lock-control write cancels the key. This includes a wrong key value, a table write and a write to an unmapped address.
- R9: After a correct key, a lock-control value other than 1 or 2 changes nothing and uses up the key.
- R10: The key register and unmapped addresses read 0, and writes to unmapped addresses change no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 7 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| seq_rd_idx | input | 6 | Entry index for the sequence engine fetch |
| seq_rd_word | output | 32 | Entry contents at `seq_rd_idx`, combinational |
| table_locked | output | 1 | High while table writes are blocked |

## Verification
The assertions check the following on every cycle:
- The lock state changes only on a lock-control write whose previous write was a correct key.
- The status bits agree with `table_locked`.
- The two read ports agree.
- A table write lands when the table is open and leaves the entry untouched when it is locked.
- The key register reads zero.
- The table is unlocked right after reset.

Some cases can only be shown by the bench's directed scenarios:
- Which particular stimuli cancel a key: a wrong key, a table write, or an unmapped write.
- That an unknown lock-control code uses up the key.
- That idle cycles keep the key armed.
- That a full clear-and-program pass over all 64 entries reads back intact.

// File: rtl/seqtab_pkg.sv
// Package: shared constants and types for the sequence table register file.
// Assumes word addressing on the register port.
package seqtab_pkg;
    localparam logic [31:0] SEQTAB_KEY   = 32'h5AF0_5AF0;
    localparam logic [31:0] CODE_LOCK    = 32'd1;
    localparam logic [31:0] CODE_UNLOCK  = 32'd2;
    localparam int unsigned KEY_ADDR     = 0;
    localparam int unsigned CTL_ADDR     = 1;
    localparam int unsigned TAB_BASE     = 2;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_e;
endpackage

// File: rtl/seqtab_addr_dec.sv
// Module: decodes a register-port word address into key, lock-control and
// table-entry hits. Assumes the table starts right after lock control.
module seqtab_addr_dec #(
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_key,
    output logic              hit_ctl,
    output logic              hit_tab,
    output logic [IDX_W-1:0]  tab_idx
);
    import seqtab_pkg::*;
    localparam int unsigned TAB_LAST = TAB_BASE + ENTRIES - 1;

    // Purpose: classify the address and derive the entry index.
    always_comb begin
        hit_key = (addr == ADDR_W'(KEY_ADDR));
        hit_ctl = (addr == ADDR_W'(CTL_ADDR));
        hit_tab = (addr >= ADDR_W'(TAB_BASE)) && (addr <= ADDR_W'(TAB_LAST));
        tab_idx = IDX_W'(addr - ADDR_W'(TAB_BASE));
    end
endmodule

// File: rtl/seqtab_lock_fsm.sv
// Module: two-step key-and-command lock state machine.
// Only a correct key write arms it. The write directly after the key write
// consumes the arming, and it may change the lock state only if it targets
// lock control with a known code.
module seqtab_lock_fsm #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_VALUE   = seqtab_pkg::SEQTAB_KEY,
    parameter logic [DATA_W-1:0] LOCK_CODE   = seqtab_pkg::CODE_LOCK,
    parameter logic [DATA_W-1:0] UNLOCK_CODE = seqtab_pkg::CODE_UNLOCK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hit_key,
    input  logic              hit_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    import seqtab_pkg::*;
    lock_state_e state_q;
    logic        armed_q;

    // Purpose: track the key arming and the lock state on each register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= hit_key && (wdata == KEY_VALUE);
            if (hit_ctl && armed_q) begin
                if (wdata == LOCK_CODE)
                    state_q <= LK_SHUT;
                else if (wdata == UNLOCK_CODE)
                    state_q <= LK_OPEN;
            end
        end
    end

    assign locked = (state_q == LK_SHUT);
endmodule

// File: rtl/seqtab_store.sv
// Module: table storage with one gated write port and two combinational read
// ports, one for software and one for the engine. Every entry clears to zero
// on reset.
module seqtab_store #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  sw_idx,
    output logic [DATA_W-1:0] sw_word,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [DATA_W-1:0] eng_word
);
    logic [DATA_W-1:0] mem_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Purpose: hold one table word and update it on a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_ok && (wr_idx == IDX_W'(g)))
                mem_q[g] <= wr_data;
        end
    end

    assign sw_word  = mem_q[sw_idx];
    assign eng_word = mem_q[eng_idx];
endmodule

// File: rtl/seqtab_regfile.sv
// Module: top of the key-protected sequence table register file.
// Assumes one register access per cycle. Reads are combinational.
module seqtab_regfile #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned ADDR_W  = 7,
    parameter logic [DATA_W-1:0] KEY_VALUE = seqtab_pkg::SEQTAB_KEY,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0]  seq_rd_idx,
    output logic [DATA_W-1:0] seq_rd_word,
    output logic              table_locked
);
    logic             hit_key, hit_ctl, hit_tab;
    logic [IDX_W-1:0] tab_idx;
    logic [DATA_W-1:0] sw_word;

    seqtab_addr_dec #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) dec_i (
        .addr    (reg_addr),
        .hit_key (hit_key),
        .hit_ctl (hit_ctl),
        .hit_tab (hit_tab),
        .tab_idx (tab_idx)
    );

    seqtab_lock_fsm #(.DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .hit_key (hit_key),
        .hit_ctl (hit_ctl),
        .wdata   (reg_wdata),
        .locked  (table_locked)
    );

    seqtab_store #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (reg_wr_en && hit_tab && !table_locked),
        .wr_idx   (tab_idx),
        .wr_data  (reg_wdata),
        .sw_idx   (tab_idx),
        .sw_word  (sw_word),
        .eng_idx  (seq_rd_idx),
        .eng_word (seq_rd_word)
    );

    // Purpose: build the register read word (status bits or table entry).
    always_comb begin
        reg_rdata = '0;
        if (hit_ctl) begin
            reg_rdata[0] = table_locked;
            reg_rdata[1] = !table_locked;
        end else if (hit_tab) begin
            reg_rdata = sw_word;
        end
    end
endmodule

// File: rtl/seqtab_regfile_chk.sv
// Module: assertion checker for seqtab_regfile, attached by bind.
module seqtab_regfile_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned ADDR_W  = 7,
    parameter logic [DATA_W-1:0] KEY_VALUE = seqtab_pkg::SEQTAB_KEY,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [IDX_W-1:0]  seq_rd_idx,
    input logic [DATA_W-1:0] seq_rd_word,
    input logic              table_locked
);
    import seqtab_pkg::*;
    localparam int unsigned TAB_LAST = TAB_BASE + ENTRIES - 1;

    logic in_tab, same_entry, last_wr_key_q;
    assign in_tab = (reg_addr >= ADDR_W'(TAB_BASE)) && (reg_addr <= ADDR_W'(TAB_LAST));
    assign same_entry = in_tab && (seq_rd_idx == IDX_W'(reg_addr - ADDR_W'(TAB_BASE)));

    // Purpose: remember whether the most recent write was a correct key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_wr_key_q <= 1'b0;
        else if (reg_wr_en)
            last_wr_key_q <= (reg_addr == ADDR_W'(KEY_ADDR)) && (reg_wdata == KEY_VALUE);
    end

    AST_RESET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !table_locked); // R1
    AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (table_locked != $past(table_locked)) |->
        ($past(reg_wr_en && reg_addr == ADDR_W'(CTL_ADDR)) && $past(last_wr_key_q))); // R7
    AST_STATUS_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(CTL_ADDR)) |->
        ($onehot(reg_rdata[1:0]) && reg_rdata[0] == table_locked)); // R4
    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        same_entry |-> (seq_rd_word == reg_rdata)); // R3
    AST_OPEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!table_locked && reg_wr_en && same_entry) |=>
        (seq_rd_idx != $past(seq_rd_idx) || seq_rd_word == $past(reg_wdata))); // R2
    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (table_locked && reg_wr_en && same_entry) |=>
        (seq_rd_idx != $past(seq_rd_idx) || seq_rd_word == $past(seq_rd_word))); // R5
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(KEY_ADDR)) |-> (reg_rdata == '0)); // R10
endmodule

bind seqtab_regfile seqtab_regfile_chk #(
    .DATA_W(DATA_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .KEY_VALUE(KEY_VALUE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .seq_rd_idx   (seq_rd_idx),
    .seq_rd_word  (seq_rd_word),
    .table_locked (table_locked)
);

// File: tb/seqtab_regfile_tb_top.sv
// Directed bench for seqtab_regfile: one task per scenario.
module seqtab_regfile_tb_top;
    localparam logic [31:0] KEY = 32'h5AF0_5AF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  seq_rd_idx = '0;
    logic [31:0] seq_rd_word;
    logic        table_locked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seqtab_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_rd_idx(seq_rd_idx),
        .seq_rd_word(seq_rd_word), .table_locked(table_locked)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic seq_chk(input logic [5:0] i, input logic [31:0] exp, input string tag);
        @(negedge clk);
        seq_rd_idx = i;
        #1;
        chk(seq_rd_word === exp, tag, seq_rd_word, exp);
    endtask

    task automatic lock_chk(input bit exp, input string tag);
        rd_chk(7'd1, exp ? 32'd1 : 32'd2, tag);
        chk(table_locked === exp, tag, {31'd0, table_locked}, {31'd0, exp});
    endtask

    task automatic t_reset;
        lock_chk(1'b0, "R1 reset status");
        rd_chk(7'd2, 32'd0, "R1 entry0 zero");
        rd_chk(7'd65, 32'd0, "R1 entry63 zero");
        seq_chk(6'd17, 32'd0, "R1 seq entry17 zero");
    endtask

    task automatic t_program_all;
        for (int i = 0; i < 64; i++) wr(7'(i + 2), 32'd0);
        for (int i = 0; i < 64; i++) wr(7'(i + 2), 32'hA500_0000 | 32'(i * 3 + 1));
        for (int i = 0; i < 64; i++) rd_chk(7'(i + 2), 32'hA500_0000 | 32'(i * 3 + 1), "R2 readback");
        seq_chk(6'd0, 32'hA500_0001, "R3 seq entry0");
        seq_chk(6'd63, 32'hA500_00BE, "R3 seq entry63");
    endtask

    task automatic t_lock;
        wr(7'd0, KEY);
        @(negedge clk); @(negedge clk);
        wr(7'd1, 32'd1);
        lock_chk(1'b1, "R4 lock after key");
    endtask

    task automatic t_locked_writes;
        wr(7'd2, 32'hDEAD_BEEF);
        wr(7'd40, 32'h1234_5678);
        rd_chk(7'd2, 32'hA500_0001, "R5 entry0 kept");
        rd_chk(7'd40, 32'hA500_0000 | 32'(38 * 3 + 1), "R5 entry38 kept");
        seq_chk(6'd0, 32'hA500_0001, "R5 seq entry0 kept");
    endtask

    task automatic t_no_key;
        wr(7'd1, 32'd2);
        lock_chk(1'b1, "R7 unlock without key");
    endtask

    task automatic t_cancel;
        wr(7'd0, KEY); wr(7'd5, 32'h0); wr(7'd1, 32'd2);
        lock_chk(1'b1, "R8 table write cancels key");
        wr(7'd0, KEY); wr(7'd0, KEY ^ 32'd1); wr(7'd1, 32'd2);
        lock_chk(1'b1, "R8 wrong key cancels key");
        wr(7'd0, KEY); wr(7'd100, 32'h0); wr(7'd1, 32'd2);
        lock_chk(1'b1, "R8 unmapped write cancels key");
    endtask

    task automatic t_bad_code;
        wr(7'd0, KEY); wr(7'd1, 32'd3);
        lock_chk(1'b1, "R9 unknown code no effect");
        wr(7'd1, 32'd2);
        lock_chk(1'b1, "R9 key consumed by unknown code");
    endtask

    task automatic t_unlock;
        wr(7'd0, KEY); wr(7'd1, 32'd2);
        lock_chk(1'b0, "R6 unlock after key");
        wr(7'd2, 32'h0000_0C0D);
        rd_chk(7'd2, 32'h0000_0C0D, "R6 write accepted after unlock");
    endtask

    task automatic t_zero_reads;
        wr(7'd0, KEY);
        rd_chk(7'd0, 32'd0, "R10 key reads zero");
        wr(7'd100, 32'hFFFF_FFFF);
        rd_chk(7'd100, 32'd0, "R10 unmapped reads zero");
        rd_chk(7'd65, 32'hA500_00BE, "R10 entry63 untouched");
        rd_chk(7'd3, 32'hA500_0004, "R10 entry1 untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program_all();
        t_lock();
        t_locked_writes();
        t_no_key();
        t_cancel();
        t_bad_code();
        t_unlock();
        t_zero_reads();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule